// File: doc/BRIEF.md
# ECC Engine Register Front-End

This block is the register and sequencing shell that sits between a 32-bit register bus and an error-correcting codec core. Software programs a block length, a parity length, a strength and a mode. It then pushes data bytes through a single data port, in word-sized or byte-sized writes. The shell forwards those bytes one at a time to the core over a valid/ready byte stream. It tells the core to begin once the expected number of bytes has been accepted.

The core returns its results through plain write ports. Parity words are stored in a parity window. Error-report words are stored in an error-list window. Done pulses set flags and counts in a status register. Status bits are cleared by writing ones to them. A single interrupt line is the OR of the status flags that are enabled.

The byte stream follows valid/ready rules. The shell holds a byte steady for as long as the core leaves ready low. The shell's own hold buffer keeps at most one data-port write, which is up to four bytes. While that buffer is not empty, `bus_ready` is low and any further data-port write is dropped. Software, or the bus fabric, must wait for `bus_ready` before it writes the data port again.

Top module: `ecc_regfront`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `cs_valid` is 0 and `bus_ready` is 1.
- R2: A write to word 0x0 loads enable (bit 0), encode (bit 2) and strength (bits 10:4). Bit 1 of that write is an init command that always reads back 0. Writing ones to word 0x8 clears the matching control bits. The fields drive `core_encode` and `core_strength`.
- R3: Word 0xC holds the block length in bits 10:0 and the parity length in bits 22:16. All other bits of this word read 0.
- R4: A word write (`bus_byte`=0) to 0x10 sends four bytes to the core, bits 7:0 first and bits 31:24 last. A byte write (`bus_byte`=1) sends only bits 7:0. Data-port writes made while enable is 0 send nothing.
- R5: While `cs_valid` is 1 and `cs_ready` is 0, `cs_byte` holds its value. `bus_ready` is 1 only when no byte is pending. A data-port write made while `bus_ready` is 0 is dropped.
- R6: `core_start` is a single-cycle pulse. It comes in the cycle after the core accepts the Nth byte. N is the block length in encode mode and the block length plus the parity length in decode mode. It is given once per init.
- R7: A core parity write with index k is read back unchanged at 0x14 + 4k.
- R8: A core error-report write with index k is read back at 0x84 + 4k. An init clears every error entry to 0, clears the byte counter and flushes any pending bytes.
- R9: In the status word at 0x184, `enc_done` sets bit 2. `dec_done` sets bit 3 and, when flagged, sets error (bit 0) and uncorrectable (bit 1). It also loads the entry count into bits 30:24 and the total bit-error count into bits 22:16.
- R10: Writing ones to the status word clears those bits. A flag that is set in the same cycle wins over its clear.
- R11: Writing ones to 0x188 sets interrupt-enable bits, and writing ones to 0x18C clears them. Both sets of bits are read at 0x190. `irq` is the OR of the status bits 3:0 that are enabled.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte address |
| bus_byte | input | 1 | Data-port write is a single byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_ready | output | 1 | Data port can take a write |
| irq | output | 1 | Interrupt |
| core_start | output | 1 | Begin pulse to the core |
| core_encode | output | 1 | Mode: 1 encode, 0 decode |
| core_strength | output | 7 | Correction strength |
| core_blk_len | output | BLK_W | Block length in bytes |
| core_par_len | output | PAR_W | Parity length in bytes |
| cs_valid | output | 1 | Stream byte valid |
| cs_ready | input | 1 | Core accepts the byte |
| cs_byte | output | 8 | Stream byte |
| par_we | input | 1 | Parity word write |
| par_idx | input | PIW | Parity word index |
| par_word | input | 32 | Parity word |
| err_we | input | 1 | Error entry write |
| err_idx | input | EIW | Error entry index |
| err_entry | input | 32 | Error entry |
| enc_done | input | 1 | Encode finished pulse |
| dec_done | input | 1 | Decode finished pulse |
| dec_err | input | 1 | Decode found errors |
| dec_uncor | input | 1 | Decode found too many errors to correct |
| dec_cnt | input | 7 | Number of error entries reported |
| dec_total | input | 7 | Total corrected bit count |

## Verification
The bench builds the block with its default parameters. The block length is 11 bits and the parity length is 7 bits. There are 28 parity words and 64 error entries, so the whole register map down to 0x190 is occupied. The encode target (block only) and the decode target (block plus parity) are both reachable with short lengths. A stalled core stream exposes the single-slot hold buffer and the dropped-write case.

// File: rtl/ecc_regfront_pkg.sv
package ecc_regfront_pkg;
  localparam int STR_W = 7;
  localparam int CNTF_W = 7;

  localparam logic [6:0] WA_CTRL  = 7'd0;
  localparam logic [6:0] WA_CCLR  = 7'd2;
  localparam logic [6:0] WA_CNT   = 7'd3;
  localparam logic [6:0] WA_DATA  = 7'd4;
  localparam logic [6:0] WA_PAR0  = 7'd5;
  localparam logic [6:0] WA_ERR0  = 7'd33;
  localparam logic [6:0] WA_STAT  = 7'd97;
  localparam logic [6:0] WA_IESET = 7'd98;
  localparam logic [6:0] WA_IECLR = 7'd99;
  localparam logic [6:0] WA_IE    = 7'd100;

  localparam int FL_ERR = 0;
  localparam int FL_UNC = 1;
  localparam int FL_ENC = 2;
  localparam int FL_DEC = 3;
  localparam int TOT_LSB = 16;
  localparam int NUM_LSB = 24;
  localparam logic [31:0] ST_MASK = 32'h7F7F_000F;

  typedef struct packed {
    logic [STR_W-1:0] strength;
    logic             encode;
    logic             enable;
  } ctrl_t;
endpackage

// File: rtl/ecc_regfront_ctrl.sv
module ecc_regfront_ctrl
  import ecc_regfront_pkg::*;
#(
  parameter int BLK_W = 11,
  parameter int PAR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [6:0]       waddr_i,
  input  logic [31:0]      wdata_i,
  output ctrl_t            ctrl_o,
  output logic             init_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [PAR_W-1:0] par_o,
  output logic [3:0]       ie_o
);
  ctrl_t ctrl_q;
  logic [BLK_W-1:0] blk_q;
  logic [PAR_W-1:0] par_q;
  logic [3:0] ie_q;
  logic unused_w;

  assign unused_w = ^wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      blk_q  <= '0;
      par_q  <= '0;
      ie_q   <= '0;
    end else if (wr_i) begin
      case (waddr_i)
        WA_CTRL: begin
          ctrl_q.enable   <= wdata_i[0];
          ctrl_q.encode   <= wdata_i[2];
          ctrl_q.strength <= wdata_i[4 +: STR_W];
        end
        WA_CCLR: begin
          ctrl_q.enable   <= ctrl_q.enable & ~wdata_i[0];
          ctrl_q.encode   <= ctrl_q.encode & ~wdata_i[2];
          ctrl_q.strength <= ctrl_q.strength & ~wdata_i[4 +: STR_W];
        end
        WA_CNT: begin
          blk_q <= wdata_i[BLK_W-1:0];
          par_q <= wdata_i[16 +: PAR_W];
        end
        WA_IESET: ie_q <= ie_q | wdata_i[3:0];
        WA_IECLR: ie_q <= ie_q & ~wdata_i[3:0];
        default: ;
      endcase
    end
  end

  assign init_o = wr_i && (waddr_i == WA_CTRL) && wdata_i[1];
  assign ctrl_o = ctrl_q;
  assign blk_o  = blk_q;
  assign par_o  = par_q;
  assign ie_o   = ie_q;

  // R11: clear-register writes leave no written bit set
  assert_ie_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && waddr_i == WA_IECLR) |=> ((ie_o & $past(wdata_i[3:0])) == 4'd0));
  // R2: clear register drops enable when bit 0 written
  assert_ctrl_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && waddr_i == WA_CCLR && wdata_i[0]) |=> !ctrl_o.enable);
endmodule

// File: rtl/ecc_regfront_feed.sv
module ecc_regfront_feed #(
  parameter int BLK_W = 11,
  parameter int PAR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             enable_i,
  input  logic             encode_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PAR_W-1:0] par_i,
  input  logic             load_i,
  input  logic             load_byte_i,
  input  logic [31:0]      wdata_i,
  output logic             load_ok_o,
  output logic             cs_valid_o,
  input  logic             cs_ready_i,
  output logic [7:0]       cs_byte_o,
  output logic             start_o
);
  localparam int CNT_W = ((BLK_W > PAR_W) ? BLK_W : PAR_W) + 1;

  logic [31:0]      hold_q;
  logic [2:0]       left_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic             started_q;
  logic             hs;

  assign hs         = cs_valid_o && cs_ready_i;
  assign cs_valid_o = (left_q != 3'd0);
  assign cs_byte_o  = hold_q[7:0];
  assign load_ok_o  = (left_q == 3'd0);
  assign target     = encode_i ? CNT_W'(blk_i) : (CNT_W'(blk_i) + CNT_W'(par_i));
  assign start_o    = enable_i && !started_q && (target != '0) && (cnt_q == target);

  always_ff @(posedge clk) begin
    if (!rst_n || init_i) begin
      hold_q    <= '0;
      left_q    <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      if (load_i && load_ok_o && enable_i) begin
        hold_q <= wdata_i;
        left_q <= load_byte_i ? 3'd1 : 3'd4;
      end else if (hs) begin
        hold_q <= {8'd0, hold_q[31:8]};
        left_q <= left_q - 3'd1;
      end
      if (hs) cnt_q <= cnt_q + 1'b1;
      if (start_o) started_q <= 1'b1;
    end
  end

  // R5: a stalled byte stays put
  assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid_o && !cs_ready_i && !init_i) |=> (cs_valid_o && $stable(cs_byte_o)));
  // R6: the begin signal never lasts two cycles
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R8: init flushes pending bytes
  assert_init_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !cs_valid_o);
endmodule

// File: rtl/ecc_regfront_store.sv
module ecc_regfront_store
  import ecc_regfront_pkg::*;
#(
  parameter int NPAR = 28,
  parameter int NERR = 64,
  parameter int PIW  = 5,
  parameter int EIW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              par_we_i,
  input  logic [PIW-1:0]    par_idx_i,
  input  logic [31:0]       par_word_i,
  input  logic              err_we_i,
  input  logic [EIW-1:0]    err_idx_i,
  input  logic [31:0]       err_entry_i,
  input  logic              enc_done_i,
  input  logic              dec_done_i,
  input  logic              dec_err_i,
  input  logic              dec_uncor_i,
  input  logic [CNTF_W-1:0] dec_cnt_i,
  input  logic [CNTF_W-1:0] dec_total_i,
  input  logic              st_wr_i,
  input  logic [31:0]       st_wdata_i,
  input  logic [PIW-1:0]    par_rd_idx_i,
  input  logic [EIW-1:0]    err_rd_idx_i,
  output logic [31:0]       par_rd_o,
  output logic [31:0]       err_rd_o,
  output logic [31:0]       status_o
);
  logic [31:0] par_q [NPAR];
  logic [31:0] err_q [NERR];
  logic [31:0] st_q;
  logic [31:0] st_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
    end else if (par_we_i && (int'(par_idx_i) < NPAR)) begin
      par_q[par_idx_i] <= par_word_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_i) begin
      for (int i = 0; i < NERR; i++) err_q[i] <= '0;
    end else if (err_we_i && (int'(err_idx_i) < NERR)) begin
      err_q[err_idx_i] <= err_entry_i;
    end
  end

  always_comb begin
    st_n = st_q & ~(st_wr_i ? st_wdata_i : 32'd0);
    if (enc_done_i) st_n[FL_ENC] = 1'b1;
    if (dec_done_i) begin
      st_n[FL_DEC] = 1'b1;
      if (dec_err_i)   st_n[FL_ERR] = 1'b1;
      if (dec_uncor_i) st_n[FL_UNC] = 1'b1;
      st_n[TOT_LSB +: CNTF_W] = dec_total_i;
      st_n[NUM_LSB +: CNTF_W] = dec_cnt_i;
    end
    st_n = st_n & ST_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign par_rd_o = (int'(par_rd_idx_i) < NPAR) ? par_q[par_rd_idx_i] : 32'd0;
  assign err_rd_o = (int'(err_rd_idx_i) < NERR) ? err_q[err_rd_idx_i] : 32'd0;
  assign status_o = st_q;

  // R9: encode completion raises its flag
  assert_enc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done_i |=> status_o[FL_ENC]);
  // R10: a lone clear write removes the written bits
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_i && !enc_done_i && !dec_done_i) |=> ((status_o & $past(st_wdata_i)) == 32'd0));
endmodule

// File: rtl/ecc_regfront.sv
module ecc_regfront
  import ecc_regfront_pkg::*;
#(
  parameter int BLK_W = 11,
  parameter int PAR_W = 7,
  parameter int NPAR  = 28,
  parameter int NERR  = 64,
  parameter int PIW   = $clog2(NPAR),
  parameter int EIW   = $clog2(NERR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [8:0]        bus_addr,
  input  logic              bus_byte,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              irq,
  output logic              core_start,
  output logic              core_encode,
  output logic [STR_W-1:0]  core_strength,
  output logic [BLK_W-1:0]  core_blk_len,
  output logic [PAR_W-1:0]  core_par_len,
  output logic              cs_valid,
  input  logic              cs_ready,
  output logic [7:0]        cs_byte,
  input  logic              par_we,
  input  logic [PIW-1:0]    par_idx,
  input  logic [31:0]       par_word,
  input  logic              err_we,
  input  logic [EIW-1:0]    err_idx,
  input  logic [31:0]       err_entry,
  input  logic              enc_done,
  input  logic              dec_done,
  input  logic              dec_err,
  input  logic              dec_uncor,
  input  logic [CNTF_W-1:0] dec_cnt,
  input  logic [CNTF_W-1:0] dec_total
);
  logic [6:0]  waddr;
  ctrl_t       ctrl;
  logic        init;
  logic [3:0]  ie;
  logic [31:0] status;
  logic [31:0] par_rd, err_rd;
  logic [6:0]  poff, eoff;
  logic [31:0] rd_val;
  logic        unused_a;

  assign waddr    = bus_addr[8:2];
  assign unused_a = ^bus_addr[1:0];

  ecc_regfront_ctrl #(.BLK_W(BLK_W), .PAR_W(PAR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .waddr_i(waddr), .wdata_i(bus_wdata),
    .ctrl_o(ctrl), .init_o(init), .blk_o(core_blk_len), .par_o(core_par_len), .ie_o(ie)
  );

  ecc_regfront_feed #(.BLK_W(BLK_W), .PAR_W(PAR_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .init_i(init), .enable_i(ctrl.enable),
    .encode_i(ctrl.encode), .blk_i(core_blk_len), .par_i(core_par_len),
    .load_i(bus_wr && (waddr == WA_DATA)), .load_byte_i(bus_byte), .wdata_i(bus_wdata),
    .load_ok_o(bus_ready), .cs_valid_o(cs_valid), .cs_ready_i(cs_ready),
    .cs_byte_o(cs_byte), .start_o(core_start)
  );

  assign poff = waddr - WA_PAR0;
  assign eoff = waddr - WA_ERR0;

  ecc_regfront_store #(.NPAR(NPAR), .NERR(NERR), .PIW(PIW), .EIW(EIW)) u_store (
    .clk(clk), .rst_n(rst_n), .init_i(init),
    .par_we_i(par_we), .par_idx_i(par_idx), .par_word_i(par_word),
    .err_we_i(err_we), .err_idx_i(err_idx), .err_entry_i(err_entry),
    .enc_done_i(enc_done), .dec_done_i(dec_done), .dec_err_i(dec_err),
    .dec_uncor_i(dec_uncor), .dec_cnt_i(dec_cnt), .dec_total_i(dec_total),
    .st_wr_i(bus_wr && (waddr == WA_STAT)), .st_wdata_i(bus_wdata),
    .par_rd_idx_i(poff[PIW-1:0]), .err_rd_idx_i(eoff[EIW-1:0]),
    .par_rd_o(par_rd), .err_rd_o(err_rd), .status_o(status)
  );

  always_comb begin
    rd_val = '0;
    if (waddr == WA_CTRL) begin
      rd_val[0]            = ctrl.enable;
      rd_val[2]            = ctrl.encode;
      rd_val[4 +: STR_W]   = ctrl.strength;
    end else if (waddr == WA_CNT) begin
      rd_val[BLK_W-1:0]    = core_blk_len;
      rd_val[16 +: PAR_W]  = core_par_len;
    end else if (waddr == WA_STAT) begin
      rd_val = status;
    end else if (waddr == WA_IE) begin
      rd_val[3:0] = ie;
    end else if ((waddr >= WA_PAR0) && (int'(poff) < NPAR)) begin
      rd_val = par_rd;
    end else if ((waddr >= WA_ERR0) && (int'(eoff) < NERR)) begin
      rd_val = err_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign irq           = |(status[3:0] & ie);
  assign core_encode   = ctrl.encode;
  assign core_strength = ctrl.strength;

  // R12: a hole in the map reads as zero
  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && waddr == 7'd1) |=> (bus_rdata == 32'd0));
  // R11: with nothing pending in status the line stays low
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:0] == 4'd0) |-> !irq);
endmodule

// File: tb/tb_ecc_regfront.sv
module tb_ecc_regfront;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {waddr 9, wdata 32, raddr 9, expected 32}
  localparam logic [81:0] VEC [NV] = '{
    {9'h000, 32'h0000_0355, 9'h000, 32'h0000_0355},
    {9'h008, 32'h0000_0004, 9'h000, 32'h0000_0351},
    {9'h000, 32'h0000_0003, 9'h000, 32'h0000_0001},
    {9'h00C, 32'hFFFF_FFFF, 9'h00C, 32'h007F_07FF},
    {9'h188, 32'h0000_0005, 9'h190, 32'h0000_0005},
    {9'h188, 32'h0000_000A, 9'h190, 32'h0000_000F},
    {9'h18C, 32'h0000_0003, 9'h190, 32'h0000_000C},
    {9'h004, 32'hFFFF_FFFF, 9'h004, 32'h0000_0000}
  };

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, bus_byte = 0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready, irq, core_start, core_encode, cs_valid, cs_ready = 0;
  logic [6:0] core_strength;
  logic [10:0] core_blk_len;
  logic [6:0] core_par_len;
  logic [7:0] cs_byte;
  logic par_we = 0, err_we = 0, enc_done = 0, dec_done = 0, dec_err = 0, dec_uncor = 0;
  logic [4:0] par_idx = '0;
  logic [5:0] err_idx = '0;
  logic [31:0] par_word = '0, err_entry = '0;
  logic [6:0] dec_cnt = '0, dec_total = '0;

  int checks = 0, errors = 0;
  logic [7:0] rx [64];
  int rx_n = 0, start_n = 0, start_at = -1, cyc = 0;
  logic start_mode = 0, stall = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_regfront dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .irq(irq), .core_start(core_start), .core_encode(core_encode),
    .core_strength(core_strength), .core_blk_len(core_blk_len), .core_par_len(core_par_len),
    .cs_valid(cs_valid), .cs_ready(cs_ready), .cs_byte(cs_byte),
    .par_we(par_we), .par_idx(par_idx), .par_word(par_word),
    .err_we(err_we), .err_idx(err_idx), .err_entry(err_entry),
    .enc_done(enc_done), .dec_done(dec_done), .dec_err(dec_err), .dec_uncor(dec_uncor),
    .dec_cnt(dec_cnt), .dec_total(dec_total)
  );

  // core model: ready pattern, byte capture, start capture
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    rdy = !stall && (cyc % 3 != 0);
    if (core_start) begin
      start_n++;
      start_at = rx_n;
      start_mode = core_encode;
    end
    if (cs_valid && rdy && rx_n < 64) begin
      rx[rx_n] = cs_byte;
      rx_n++;
    end
    cs_ready = rdy;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic byt = 0);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_byte = byt;
    @(negedge clk);
    bus_wr = 0; bus_byte = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic feed(input logic [31:0] d, input logic byt);
    while (!bus_ready) @(negedge clk);
    wr(9'h010, d, byt);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_dec(input logic e, input logic u, input logic [6:0] c, input logic [6:0] t);
    @(negedge clk);
    dec_done = 1; dec_err = e; dec_uncor = u; dec_cnt = c; dec_total = t;
    @(negedge clk);
    dec_done = 0; dec_err = 0; dec_uncor = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_valid", {31'd0, cs_valid}, 32'd0);
    chk("R1 bus_ready", {31'd0, bus_ready}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(9'h000, rv); chk("R1 ctrl", rv, 32'd0);
    rd(9'h00C, rv); chk("R1 count", rv, 32'd0);
    rd(9'h184, rv); chk("R1 status", rv, 32'd0);
    rd(9'h190, rv); chk("R1 ie", rv, 32'd0);

    // register table: R2 R3 R11 R12
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][81:73], VEC[i][72:41]);
      rd(VEC[i][40:32], rv);
      chk($sformatf("R2/R3/R11/R12 vec%0d", i), rv, VEC[i][31:0]);
    end

    // encode: block 6, parity 3
    wr(9'h00C, 32'h0003_0006);
    wr(9'h000, 32'h0000_0357);
    rx_n = 0; start_n = 0;
    feed(32'h4433_2211, 0);
    feed(32'hFFFF_FF55, 1);
    feed(32'h0000_0066, 1);
    idle(20);
    chk("R4 enc byte count", rx_n, 6);
    for (int i = 0; i < 6; i++)
      chk($sformatf("R4 enc byte %0d", i), {24'd0, rx[i]}, 32'h11 * (i + 1));
    chk("R6 enc start count", start_n, 1);
    chk("R6 enc start after byte", start_at, 6);
    chk("R6 enc mode", {31'd0, start_mode}, 32'd1);
    chk("R2 strength out", {25'd0, core_strength}, 32'h35);
    @(negedge clk);
    par_we = 1; par_idx = 5'd0; par_word = 32'h00C3_B2A1;
    @(negedge clk);
    par_we = 0;
    enc_done = 1;
    @(negedge clk);
    enc_done = 0;
    rd(9'h014, rv); chk("R7 parity word", rv, 32'h00C3_B2A1);
    rd(9'h184, rv); chk("R9 enc flag", rv, 32'h0000_0004);
    chk("R11 irq on", {31'd0, irq}, 32'd1);
    wr(9'h184, 32'h0000_0004);
    rd(9'h184, rv); chk("R10 clear enc", rv, 32'd0);
    chk("R11 irq off", {31'd0, irq}, 32'd0);

    // decode: block 2, parity 2
    wr(9'h00C, 32'h0002_0002);
    rx_n = 0; start_n = 0;
    wr(9'h000, 32'h0000_0003);
    feed(32'hDDCC_BBAA, 0);
    idle(20);
    chk("R4 dec byte count", rx_n, 4);
    chk("R4 dec first byte", {24'd0, rx[0]}, 32'hAA);
    chk("R4 dec last byte", {24'd0, rx[3]}, 32'hDD);
    chk("R6 dec start after byte", start_at, 4);
    chk("R6 dec mode", {31'd0, start_mode}, 32'd0);
    @(negedge clk);
    err_we = 1; err_idx = 6'd0; err_entry = 32'h00F0_0003;
    @(negedge clk);
    err_idx = 6'd1; err_entry = 32'h0100_0007;
    @(negedge clk);
    err_we = 0;
    pulse_dec(1, 0, 7'd2, 7'd5);
    rd(9'h184, rv); chk("R9 dec status", rv, 32'h0205_0009);
    rd(9'h084, rv); chk("R8 err entry 0", rv, 32'h00F0_0003);
    rd(9'h088, rv); chk("R8 err entry 1", rv, 32'h0100_0007);
    chk("R11 irq dec", {31'd0, irq}, 32'd1);
    wr(9'h184, 32'h0000_0001);
    rd(9'h184, rv); chk("R10 partial clear", rv, 32'h0205_0008);
    // clear and set of the same bit in one cycle
    @(negedge clk);
    bus_wr = 1; bus_addr = 9'h184; bus_wdata = 32'h0000_0004; enc_done = 1;
    @(negedge clk);
    bus_wr = 0; enc_done = 0;
    rd(9'h184, rv); chk("R10 set wins", rv, 32'h0205_000C);
    wr(9'h184, 32'hFFFF_FFFF);
    rd(9'h184, rv); chk("R10 clear all", rv, 32'd0);
    wr(9'h000, 32'h0000_0002);
    rd(9'h084, rv); chk("R8 init clears entry", rv, 32'd0);
    pulse_dec(0, 1, 7'd0, 7'd0);
    rd(9'h184, rv); chk("R9 uncorrectable", rv, 32'h0000_000A);
    wr(9'h184, 32'hFFFF_FFFF);

    // enable off: data port ignored
    rx_n = 0;
    wr(9'h010, 32'h1234_5678);
    idle(10);
    chk("R4 disabled no bytes", rx_n, 0);
    chk("R4 disabled no valid", {31'd0, cs_valid}, 32'd0);

    // stalled stream, dropped write: block 4, parity 0, decode
    wr(9'h00C, 32'h0000_0004);
    wr(9'h000, 32'h0000_0003);
    rx_n = 0; start_n = 0; start_at = -1;
    stall = 1;
    idle(2);
    wr(9'h010, 32'h0403_0201);
    chk("R5 ready low when pending", {31'd0, bus_ready}, 32'd0);
    wr(9'h010, 32'h0000_0099, 1);
    idle(4);
    chk("R5 held byte", {24'd0, cs_byte}, 32'h01);
    chk("R5 no start while stalled", start_n, 0);
    stall = 0;
    idle(20);
    chk("R5 dropped write", rx_n, 4);
    chk("R5 last byte", {24'd0, rx[3]}, 32'h04);
    chk("R6 start once", start_n, 1);
    chk("R6 start after byte", start_at, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule